// File: doc/BRIEF.md
# Shared-Table Distributed-Arithmetic Inner-Product Cell

This block computes two signed inner products over one four-sample input vector, using distributed arithmetic. It holds a sixteen-word table. Word k of that table is the sum of the samples whose matching bit of k is set. Words are loaded one per clock through a write port during a sixteen-cycle fill period at the start of each iteration. Filling the table from the samples is left to a neighbouring block.

After the fill, the same table is read twice. The first pass addresses it with weight bit-slices and produces a partial filter output. The second pass addresses it with error bit-slices and produces a partial weight-increment term. In both passes the slices arrive one per clock, least significant first. Each table read is added into a running sum with weight 2^j for slice j. On the final slice, which carries the sign bits, the word is subtracted instead: it is bit-inverted and a carry of one is added.

The filter result is presented at full width. The increment result is scaled by a power-of-two step size, applied as a fixed arithmetic right shift. Each result comes with a one-cycle strobe and is held until the next result of its kind.

Top module: `da_subcell`

## Requirements
- R1: While reset is asserted and after its release, `filt_out` and `incr_out` are zero and both strobes are low until the first result is produced.
- R2: A high `tbl_we` stores `tbl_wdata` at `tbl_waddr` at the next clock edge. Bit i of `slice_addr` is the bit of sample i (i = 0..3), so the word at address k must be the sum of the samples whose bit i of k is 1.
- R3: In the filter phase (`phase_corr` = 0), slices 0..SLICE_N-1 of four SLICE_N-bit two's-complement weights are applied one per `slice_vld` cycle, LSB first, with `slice_sign` = 1 on slice SLICE_N-1 only. The result is sum of sample_i * weight_i as an ACC_W-bit two's-complement value.
- R4: In the correlation phase (`phase_corr` = 1), error slices applied to the same table contents give sum of sample_i * error_i arithmetically right-shifted by MU_SHIFT, which rounds toward minus infinity.
- R5: `filt_valid` is high for exactly the one cycle that follows the clock edge sampling a sign slice with `phase_corr` = 0, and `filt_out` carries the result in that cycle.
- R6: At most one strobe is high in any cycle. No strobe follows an edge that did not sample `slice_vld` and `slice_sign` both high.
- R7: `incr_valid` is high for exactly the one cycle after the edge sampling a sign slice with `phase_corr` = 1, and `incr_out` carries the scaled result then.
- R8: Each result output keeps its value until a new result of its own phase is produced.
- R9: Cycles with `slice_vld` low leave the running sum and the slice position unchanged, so idle gaps between slices do not alter the result.
- R10: The running sum and slice position return to zero after every sign slice, so a correlation phase that immediately follows a filter phase starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 4 | Table write address |
| tbl_wdata | input | ENTRY_W | Table word, signed |
| slice_addr | input | 4 | Bit-slice used as table read address |
| slice_vld | input | 1 | Slice present this cycle |
| slice_sign | input | 1 | Slice is the sign slice: subtract and finish |
| phase_corr | input | 1 | 0 routes result to filter output, 1 to increment output |
| filt_out | output | ACC_W | Filter partial sum, signed |
| filt_valid | output | 1 | One-cycle strobe for filt_out |
| incr_out | output | ACC_W | Scaled weight-increment partial sum, signed |
| incr_valid | output | 1 | One-cycle strobe for incr_out |

## Verification
The hardest situation to reach is an extreme operand product. Here every sample is the most negative value and every weight or error is also the most negative value. The sign-slice subtraction then meets the largest table word, and the accumulator runs close to its width limit. Random vectors almost never land there, so the stimulus adds directed iterations with all-minimum, all-maximum and mixed-extreme operands. It also inserts random idle gaps between slices and runs the correlation pass directly after the filter pass, to show that the sum is cleared at the boundary.

// File: rtl/dsub_pkg.sv
package dsub_pkg;
    localparam int TAPS  = 4;
    localparam int DEPTH = 1 << TAPS;
    typedef enum logic {PH_FILT = 1'b0, PH_CORR = 1'b1} phase_e;
endpackage

// File: rtl/dsub_table.sv
module dsub_table #(
    parameter int TAPS    = 4,
    parameter int ENTRY_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [TAPS-1:0]    waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [TAPS-1:0]    raddr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << TAPS;

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] words;
    } tbl_s;

    tbl_s tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we) tbl_d.words[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rdata = tbl_q.words[raddr];
endmodule

// File: rtl/dsub_accum.sv
module dsub_accum #(
    parameter int ENTRY_W = 10,
    parameter int SLICE_N = 8,
    parameter int ACC_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slice_vld,
    input  logic               slice_sign,
    input  logic [ENTRY_W-1:0] word,
    output logic               fire,
    output logic [ACC_W-1:0]   total
);
    localparam int CNT_W = (SLICE_N > 1) ? $clog2(SLICE_N) : 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] pos;
    } acc_s;

    acc_s st_d, st_q;
    logic [ACC_W-1:0] word_ext;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] opnd;
    logic [ACC_W-1:0] sum;

    always_comb begin
        word_ext = {{(ACC_W-ENTRY_W){word[ENTRY_W-1]}}, word};
        term     = word_ext << st_q.pos;
        opnd     = term ^ {ACC_W{slice_sign}};
        sum      = st_q.acc + opnd + {{(ACC_W-1){1'b0}}, slice_sign};
        st_d     = st_q;
        if (slice_vld) begin
            if (slice_sign) begin
                st_d.acc = '0;
                st_d.pos = '0;
            end else begin
                st_d.acc = sum;
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire  = slice_vld & slice_sign;
    assign total = sum;
endmodule

// File: rtl/dsub_route.sv
module dsub_route #(
    parameter int ACC_W    = 18,
    parameter int MU_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             phase_corr,
    input  logic [ACC_W-1:0] total,
    output logic [ACC_W-1:0] filt_out,
    output logic             filt_valid,
    output logic [ACC_W-1:0] incr_out,
    output logic             incr_valid
);
    typedef struct packed {
        logic [ACC_W-1:0] filt;
        logic             filt_vld;
        logic [ACC_W-1:0] incr;
        logic             incr_vld;
    } out_s;

    out_s o_d, o_q;
    logic [ACC_W-1:0] scaled;

    always_comb begin
        scaled     = $signed(total) >>> MU_SHIFT;
        o_d        = o_q;
        o_d.filt_vld = 1'b0;
        o_d.incr_vld = 1'b0;
        if (fire) begin
            if (phase_corr == dsub_pkg::PH_CORR) begin
                o_d.incr     = scaled;
                o_d.incr_vld = 1'b1;
            end else begin
                o_d.filt     = total;
                o_d.filt_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign filt_out   = o_q.filt;
    assign filt_valid = o_q.filt_vld;
    assign incr_out   = o_q.incr;
    assign incr_valid = o_q.incr_vld;
endmodule

// File: rtl/da_subcell.sv
module da_subcell #(
    parameter int SAMPLE_W = 8,
    parameter int SLICE_N  = 8,
    parameter int MU_SHIFT = 3,
    parameter int ENTRY_W  = SAMPLE_W + 2,
    parameter int ACC_W    = ENTRY_W + SLICE_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [dsub_pkg::TAPS-1:0] tbl_waddr,
    input  logic [ENTRY_W-1:0]       tbl_wdata,
    input  logic [dsub_pkg::TAPS-1:0] slice_addr,
    input  logic                     slice_vld,
    input  logic                     slice_sign,
    input  logic                     phase_corr,
    output logic [ACC_W-1:0]         filt_out,
    output logic                     filt_valid,
    output logic [ACC_W-1:0]         incr_out,
    output logic                     incr_valid
);
    logic [ENTRY_W-1:0] word;
    logic               fire;
    logic [ACC_W-1:0]   total;

    dsub_table #(.TAPS(dsub_pkg::TAPS), .ENTRY_W(ENTRY_W)) i_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_waddr),
        .wdata(tbl_wdata), .raddr(slice_addr), .rdata(word)
    );

    dsub_accum #(.ENTRY_W(ENTRY_W), .SLICE_N(SLICE_N), .ACC_W(ACC_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .slice_vld(slice_vld), .slice_sign(slice_sign),
        .word(word), .fire(fire), .total(total)
    );

    dsub_route #(.ACC_W(ACC_W), .MU_SHIFT(MU_SHIFT)) i_route (
        .clk(clk), .rst_n(rst_n), .fire(fire), .phase_corr(phase_corr),
        .total(total), .filt_out(filt_out), .filt_valid(filt_valid),
        .incr_out(incr_out), .incr_valid(incr_valid)
    );
endmodule

// File: rtl/dsub_subcell_chk.sv
module dsub_subcell_chk #(
    parameter int ACC_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slice_vld,
    input logic             slice_sign,
    input logic             phase_corr,
    input logic [ACC_W-1:0] filt_out,
    input logic             filt_valid,
    input logic [ACC_W-1:0] incr_out,
    input logic             incr_valid
);
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({filt_valid, incr_valid}));

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(slice_vld && slice_sign) |=> (!filt_valid && !incr_valid));

    assert_filt_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_vld && slice_sign && !phase_corr) |=> filt_valid);

    assert_incr_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_vld && slice_sign && phase_corr) |=> incr_valid);

    assert_hold_filt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(slice_vld && slice_sign && !phase_corr) |=> $stable(filt_out));

    assert_hold_incr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(slice_vld && slice_sign && phase_corr) |=> $stable(incr_out));
endmodule

bind da_subcell dsub_subcell_chk #(.ACC_W(ACC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .slice_vld(slice_vld), .slice_sign(slice_sign),
    .phase_corr(phase_corr), .filt_out(filt_out), .filt_valid(filt_valid),
    .incr_out(incr_out), .incr_valid(incr_valid)
);

// File: tb/test_da_subcell.sv
module test_da_subcell;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_W = 8;
    localparam int SLICE_N  = 8;
    localparam int MU_SHIFT = 3;
    localparam int ENTRY_W  = SAMPLE_W + 2;
    localparam int ACC_W    = ENTRY_W + SLICE_N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [3:0] tbl_waddr = '0;
    logic [ENTRY_W-1:0] tbl_wdata = '0;
    logic [3:0] slice_addr = '0;
    logic slice_vld = 1'b0;
    logic slice_sign = 1'b0;
    logic phase_corr = 1'b0;
    logic [ACC_W-1:0] filt_out;
    logic filt_valid;
    logic [ACC_W-1:0] incr_out;
    logic incr_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int xs [4];
    int ws [4];
    int es [4];
    int last_filt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_subcell #(.SAMPLE_W(SAMPLE_W), .SLICE_N(SLICE_N), .MU_SHIFT(MU_SHIFT)) i_da_subcell (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .slice_addr(slice_addr), .slice_vld(slice_vld),
        .slice_sign(slice_sign), .phase_corr(phase_corr), .filt_out(filt_out),
        .filt_valid(filt_valid), .incr_out(incr_out), .incr_valid(incr_valid)
    );

    function automatic int dot(input int a [4], input int b [4]);
        int s = 0;
        for (int i = 0; i < 4; i++) s += a[i] * b[i];
        return s;
    endfunction

    function automatic int sx(input logic [ACC_W-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_table();
        for (int k = 0; k < 16; k++) begin
            int s = 0;
            for (int i = 0; i < 4; i++) if (k[i]) s += xs[i];
            @(negedge clk);
            tbl_we = 1'b1; tbl_waddr = 4'(k); tbl_wdata = ENTRY_W'(s);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_phase(input int v [4], input bit corr, input bit gaps);
        for (int j = 0; j < SLICE_N; j++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                slice_vld = 1'b0; slice_addr = 4'($urandom);
                slice_sign = 1'($urandom);
                @(negedge clk);
            end
            for (int i = 0; i < 4; i++) slice_addr[i] = v[i][j];
            slice_vld = 1'b1; slice_sign = (j == SLICE_N-1); phase_corr = corr;
            @(negedge clk);
        end
        slice_vld = 1'b0; slice_sign = 1'b0;
    endtask

    task automatic iteration(input bit gaps);
        int ef, ei;
        ef = dot(xs, ws);
        ei = dot(xs, es) >>> MU_SHIFT;
        fill_table();
        run_phase(ws, 1'b0, gaps);
        check("R5 filt_valid", int'(filt_valid), 1);
        check("R3 filter dot product", sx(filt_out), ef);
        check("R6 incr idle", int'(incr_valid), 0);
        last_filt = ef;
        run_phase(es, 1'b1, gaps);
        check("R7 incr_valid", int'(incr_valid), 1);
        check("R4 scaled increment", sx(incr_out), ei);
        check("R8 filt held", sx(filt_out), last_filt);
        @(negedge clk);
        check("R6 strobe one cycle", int'(filt_valid | incr_valid), 0);
    endtask

    task automatic set_all(input int x, input int w, input int e);
        for (int i = 0; i < 4; i++) begin xs[i] = x; ws[i] = w; es[i] = e; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R1 filt_out reset", sx(filt_out), 0);
        check("R1 incr_out reset", sx(incr_out), 0);
        check("R1 strobes reset", int'(filt_valid | incr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(filt_valid | incr_valid) + sx(filt_out), 0);

        // R2 R3 R4: directed extremes
        set_all(-128, -128, -128); iteration(1'b0);
        set_all(127, 127, 127);    iteration(1'b0);
        set_all(-128, 127, -1);    iteration(1'b0);
        set_all(0, -128, 127);     iteration(1'b0);
        xs = '{1, 0, 0, 0}; ws = '{-1, 5, 5, 5}; es = '{-3, 9, 9, 9};
        iteration(1'b0);

        // R9 R10: random vectors with idle gaps, back-to-back phases
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 4; i++) begin
                xs[i] = int'($signed(8'($urandom)));
                ws[i] = int'($signed(8'($urandom)));
                es[i] = int'($signed(8'($urandom)));
            end
            iteration(n % 2 == 0);
        end

        repeat (4) @(negedge clk);
        check("R8 idle hold", sx(filt_out), last_filt);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule